// File: doc/BRIEF.md
# Matrix Keypad Scanner

This block scans a key matrix of four return lines and eight scan strobes, which covers 32 keys. It pulls one strobe low at a time for a fixed number of clocks and samples the return lines once inside each strobe. After the last strobe comes a short gap with every strobe high. During the gap the block moves the key it found into a key register and raises a request line so the host knows there is a new key to read.

The host reads with a one-clock read strobe. That opens a busy window of fixed length. While the window is open the key register is frozen, so the value the host sees cannot change under it. The read also drops the request. An enable input stops the strobes and the detection, but the scan timing keeps running.

When the user rolls from one key to the next, the key found first in a scan cycle is the one reported. If several return lines are low during the same strobe, the lowest-numbered return line wins. This way the key word always names exactly one key.

Top module: `keypad_scanner`

## Requirements
- R1: Strobes `strobe_n[0]` through `strobe_n[7]` go low one at a time and in ascending order. Each stays low for `T_STROBE` clocks. The gap that follows lasts `GAP_CYC` clocks with all strobes high, and then the cycle repeats. At most one strobe is low at any time.
- R2: A key counts as pressed when its return line is low while its strobe is low. The return lines are sampled on one edge per strobe: the edge that ends strobe clock number `3*T_STROBE/4`, counting from 0.
- R3: The key word has this layout. Bits 7..4 are a one-hot flag for return lines 3..0. Bit 3 is always 0. Bits 2..0 hold the strobe number in binary. For example, return 2 with strobe 2 gives 8'h42.
- R4: The key register is loaded on the edge that ends the second gap clock. It takes the key detected in that scan cycle, or 8'h00 if no key was detected. It holds that value until the next load.
- R5: A read is accepted when `rd_stb` is high and `rd_busy` is low. `rd_busy` is then high for `RD_CYC` clocks, starting in the next clock. The key register does not load on the accepting edge or while `rd_busy` is high. A read strobe that arrives while busy is ignored.
- R6: While `scan_en` is low, all strobes are high and no key is detected. A load in that state writes 8'h00 and does not raise the request.
- R7: `key_req` rises on a load edge that carries a detected key. It falls on the edge that accepts a read. It stays low until a later load that carries a detected key.
- R8: Once a key has been detected in a scan cycle, keys seen in later strobes of the same cycle are ignored.
- R9: If more than one return line is low in the same sample, only the lowest-numbered one is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_en | input | 1 | Enables the strobes and key detection |
| ret_n | input | 4 | Return lines, low means pressed |
| rd_stb | input | 1 | One-clock host read request |
| strobe_n | output | 8 | Scan strobes, active low |
| key_data | output | 8 | Key register |
| key_req | output | 1 | Request: a new key is waiting |
| rd_busy | output | 1 | Read window open, register frozen |

## Verification
The hardest case to reach is a read whose busy window overlaps the load edge. Here the stimulus has to land on one clock out of each scan cycle, and the frozen value has to differ from the key that would have been loaded. The bench tracks the scan position in its model and waits until it is three clocks before the load. It then raises the read strobe while a new key is held, so that the stale word stays visible and the new word only shows up one scan cycle later. Roll-over is reached by pressing a second key partway through a cycle, after the first key's strobe has already been sampled.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

    localparam int STROBES = 8;
    localparam int RETURNS = 4;
    localparam int IDX_W   = $clog2(STROBES);
    localparam int KEY_W   = RETURNS + 1 + IDX_W;

    typedef enum logic {
        PH_SCAN = 1'b0,
        PH_GAP  = 1'b1
    } phase_e;

    typedef struct packed {
        logic [RETURNS-1:0] hit;
        logic               pad;
        logic [IDX_W-1:0]   idx;
    } key_word_t;

    // Lowest-numbered low return line wins.
    function automatic key_word_t make_word(input logic [RETURNS-1:0] low_n,
                                            input logic [IDX_W-1:0]   idx);
        key_word_t w;
        logic      taken;
        w.hit = '0;
        w.pad = 1'b0;
        w.idx = idx;
        taken = 1'b0;
        for (int i = 0; i < RETURNS; i++) begin
            if (!low_n[i] && !taken) begin
                w.hit[i] = 1'b1;
                taken    = 1'b1;
            end
        end
        return w;
    endfunction

endpackage

// File: rtl/kpd_scan_timer.sv
module kpd_scan_timer
    import kpd_pkg::*;
#(
    parameter int T_STROBE = 8,
    parameter int GAP_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] idx,
    output logic             scanning,
    output logic             sample_now,
    output logic             load_now,
    output logic             restart
);
    localparam int TW = $clog2(T_STROBE);
    localparam int GW = $clog2(GAP_CYC);
    localparam logic [TW-1:0]    SAMPLE_T = TW'(3 * T_STROBE / 4);
    localparam logic [TW-1:0]    LAST_T   = TW'(T_STROBE - 1);
    localparam logic [GW-1:0]    LAST_G   = GW'(GAP_CYC - 1);
    localparam logic [IDX_W-1:0] LAST_S   = IDX_W'(STROBES - 1);

    phase_e          phase;
    logic [TW-1:0]   tick;
    logic [GW-1:0]   gcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_SCAN;
            tick  <= '0;
            idx   <= '0;
            gcnt  <= '0;
        end else if (phase == PH_SCAN) begin
            if (tick == LAST_T) begin
                tick <= '0;
                if (idx == LAST_S) begin
                    idx   <= '0;
                    phase <= PH_GAP;
                    gcnt  <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end else begin
                tick <= tick + 1'b1;
            end
        end else begin
            if (gcnt == LAST_G) begin
                phase <= PH_SCAN;
                gcnt  <= '0;
            end else begin
                gcnt <= gcnt + 1'b1;
            end
        end
    end

    always_comb begin
        scanning   = (phase == PH_SCAN);
        sample_now = scanning && (tick == SAMPLE_T);
        load_now   = !scanning && (gcnt == GW'(1));
        restart    = !scanning && (gcnt == LAST_G);
    end

endmodule

// File: rtl/kpd_strobe_drive.sv
module kpd_strobe_drive
    import kpd_pkg::*;
(
    input  logic               scanning,
    input  logic               en,
    input  logic [IDX_W-1:0]   idx,
    output logic [STROBES-1:0] strobe_n
);
    for (genvar i = 0; i < STROBES; i++) begin : g_strobe
        assign strobe_n[i] = !(scanning && en && (idx == IDX_W'(i)));
    end
endmodule

// File: rtl/kpd_key_capture.sv
module kpd_key_capture
    import kpd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               sample_now,
    input  logic               restart,
    input  logic [RETURNS-1:0] ret_n,
    input  logic [IDX_W-1:0]   idx,
    output logic               found,
    output key_word_t          word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            found <= 1'b0;
            word  <= '0;
        end else if (restart) begin
            found <= 1'b0;
        end else if (sample_now && en && !found && !(&ret_n)) begin
            found <= 1'b1;
            word  <= make_word(ret_n, idx);
        end
    end
endmodule

// File: rtl/kpd_host_port.sv
module kpd_host_port
    import kpd_pkg::*;
#(
    parameter int RD_CYC = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load_now,
    input  logic      found,
    input  key_word_t word,
    input  logic      rd_stb,
    output key_word_t key_reg,
    output logic      req,
    output logic      busy
);
    localparam int BW = $clog2(RD_CYC + 1);

    logic [BW-1:0] bcnt;
    logic          accept;
    logic          load_ok;

    always_comb begin
        busy    = (bcnt != '0);
        accept  = rd_stb && !busy;
        load_ok = load_now && !busy && !accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bcnt    <= '0;
            key_reg <= '0;
            req     <= 1'b0;
        end else begin
            if (accept)    bcnt <= BW'(RD_CYC);
            else if (busy) bcnt <= bcnt - 1'b1;

            if (load_ok) key_reg <= found ? word : '0;

            if (accept)                req <= 1'b0;
            else if (load_ok && found) req <= 1'b1;
        end
    end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
    import kpd_pkg::*;
#(
    parameter int T_STROBE = 8,
    parameter int GAP_CYC  = 4,
    parameter int RD_CYC   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scan_en,
    input  logic [RETURNS-1:0] ret_n,
    input  logic               rd_stb,
    output logic [STROBES-1:0] strobe_n,
    output logic [KEY_W-1:0]   key_data,
    output logic               key_req,
    output logic               rd_busy
);
    logic [IDX_W-1:0] idx;
    logic             scanning, sample_now, load_now, restart, found;
    key_word_t        word, key_reg;

    kpd_scan_timer #(.T_STROBE(T_STROBE), .GAP_CYC(GAP_CYC)) u_timer (
        .clk(clk), .rst(rst), .idx(idx), .scanning(scanning),
        .sample_now(sample_now), .load_now(load_now), .restart(restart)
    );

    kpd_strobe_drive u_drive (
        .scanning(scanning), .en(scan_en), .idx(idx), .strobe_n(strobe_n)
    );

    kpd_key_capture u_cap (
        .clk(clk), .rst(rst), .en(scan_en), .sample_now(sample_now),
        .restart(restart), .ret_n(ret_n), .idx(idx), .found(found), .word(word)
    );

    kpd_host_port #(.RD_CYC(RD_CYC)) u_host (
        .clk(clk), .rst(rst), .load_now(load_now), .found(found), .word(word),
        .rd_stb(rd_stb), .key_reg(key_reg), .req(key_req), .busy(rd_busy)
    );

    assign key_data = key_reg;
endmodule

// File: rtl/keypad_scanner_chk.sv
module keypad_scanner_chk
    import kpd_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               scan_en,
    input logic               rd_stb,
    input logic [STROBES-1:0] strobe_n,
    input logic [KEY_W-1:0]   key_data,
    input logic               key_req,
    input logic               rd_busy
);
    p_one_strobe_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~strobe_n));

    p_idle_strobes_r6: assert property (@(posedge clk) disable iff (rst)
        !scan_en |-> (strobe_n == '1));

    p_word_shape_r3: assert property (@(posedge clk) disable iff (rst)
        !key_data[IDX_W] && ($countones(key_data[KEY_W-1:KEY_W-RETURNS]) <= 1));

    p_empty_is_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (key_data[KEY_W-1:KEY_W-RETURNS] == '0) |-> (key_data == '0));

    p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        rd_busy |=> $stable(key_data));

    p_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !rd_busy) |=> !key_req);
endmodule

bind keypad_scanner keypad_scanner_chk i_chk (.*);

// File: tb/test_keypad_scanner.sv
module test_keypad_scanner;
    localparam int T  = 8;
    localparam int G  = 4;
    localparam int RD = 6;
    localparam int P  = 8 * T + G;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic [3:0] ret_n;
    logic [7:0] strobe_n;
    logic [7:0] key_data;
    logic       key_req, rd_busy;

    logic [31:0] keys = '0;  // bit r*8+s : return r, strobe s pressed

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int         mpos = 0;
    bit         mfound = 0;
    logic [7:0] mcand = '0;
    logic [7:0] mkreg = '0;
    bit         mreq = 0;
    int         mbcnt = 0;

    always #5 clk = ~clk;

    keypad_scanner #(.T_STROBE(T), .GAP_CYC(G), .RD_CYC(RD)) i_keypad_scanner (
        .clk(clk), .rst(rst), .scan_en(scan_en), .ret_n(ret_n), .rd_stb(rd_stb),
        .strobe_n(strobe_n), .key_data(key_data), .key_req(key_req), .rd_busy(rd_busy)
    );

    always_comb begin
        for (int r = 0; r < 4; r++) ret_n[r] = !(|(keys[r*8 +: 8] & ~strobe_n));
    end

    function automatic logic [7:0] exp_strobe(int pos, bit en);
        logic [7:0] v;
        v = 8'hFF;
        if (en && pos < 8 * T) v[pos / T] = 1'b0;
        return v;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_next();
        logic [7:0] ms;
        logic [3:0] mret;
        bit accept, load_ok;
        ms = exp_strobe(mpos, scan_en);
        for (int r = 0; r < 4; r++) mret[r] = !(|(keys[r*8 +: 8] & ~ms));
        accept  = rd_stb && mbcnt == 0;
        load_ok = (mpos == 8 * T + 1) && mbcnt == 0 && !accept;
        if (load_ok) begin
            mkreg = mfound ? mcand : 8'h00;
            if (mfound) mreq = 1;
        end
        if (accept) mreq = 0;
        if (mpos == P - 1) mfound = 0;
        else if (mpos < 8 * T && (mpos % T) == 3 * T / 4 && scan_en && !mfound && mret != 4'hF) begin
            mfound = 1;
            mcand  = {4'h0, 1'b0, 3'(mpos / T)};
            for (int r = 0; r < 4; r++) begin
                if (!mret[r]) begin
                    mcand[4 + r] = 1'b1;
                    break;
                end
            end
        end
        if (accept) mbcnt = RD;
        else if (mbcnt > 0) mbcnt--;
        mpos = (mpos + 1) % P;
    endtask

    task automatic compare();
        logic [7:0] es;
        es = exp_strobe(mpos, scan_en);
        chk(strobe_n === es, "R1 strobe pattern", strobe_n, es);
        chk(key_data === mkreg, "R4 key register", key_data, mkreg);
        chk(key_req === mreq, "R7 request", key_req, mreq);
        chk(rd_busy === (mbcnt != 0), "R5 busy", rd_busy, mbcnt != 0);
    endtask

    task automatic tick();
        model_next();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic wait_pos(int p);
        while (mpos != p) tick();
    endtask

    task automatic do_read();
        rd_stb = 1'b1;
        tick();
        rd_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(key_data === 8'h00, "R4 reset key", key_data, 0);
        chk(key_req === 1'b0, "R7 reset req", key_req, 0);
        chk(rd_busy === 1'b0, "R5 reset busy", rd_busy, 0);
        chk(strobe_n === 8'hFF, "R6 reset strobes off", strobe_n, 8'hFF);

        // no key: load gives zero
        scan_en = 1'b1;
        wait_pos(8 * T + 3);
        chk(key_data === 8'h00, "R4 no key zero", key_data, 0);

        // single key return 2 / strobe 2
        keys[2*8 + 2] = 1'b1;
        wait_pos(0);
        wait_pos(8 * T + 3);
        chk(key_data === 8'h42, "R3 K2/S2 word", key_data, 8'h42);
        chk(key_req === 1'b1, "R7 req raised", key_req, 1);

        // read clears request; released key then loads zero
        wait_pos(10);
        do_read();
        chk(key_req === 1'b0, "R7 read clears req", key_req, 0);
        chk(rd_busy === 1'b1, "R5 busy opens", rd_busy, 1);
        rd_stb = 1'b1;   // strobe while busy: ignored
        tick();
        rd_stb = 1'b0;
        keys = '0;
        begin
            int n = 0;
            while (rd_busy) begin
                n++;
                tick();
            end
            chk(n == RD - 1, "R5 busy length", n + 1, RD);
        end
        wait_pos(8 * T + 3);
        chk(key_data === 8'h00, "R2 released key", key_data, 0);
        chk(key_req === 1'b0, "R7 req stays low", key_req, 0);

        // roll-over: return 1 / strobe 5 first, return 3 / strobe 6 added later
        wait_pos(0);
        keys[1*8 + 5] = 1'b1;
        wait_pos(6 * T + 1);
        keys[3*8 + 6] = 1'b1;
        wait_pos(8 * T + 3);
        chk(key_data === 8'h25, "R8 first key kept", key_data, 8'h25);
        keys = '0;
        do_read();

        // two returns in one strobe: lowest wins
        keys[0*8 + 4] = 1'b1;
        keys[3*8 + 4] = 1'b1;
        wait_pos(0);
        wait_pos(8 * T + 3);
        chk(key_data === 8'h14, "R9 lowest return", key_data, 8'h14);
        keys = '0;

        // read window over the load edge freezes the register
        keys[3*8 + 7] = 1'b1;
        wait_pos(0);
        wait_pos(8 * T - 2);
        do_read();
        wait_pos(8 * T + 3);
        chk(key_data === 8'h14, "R5 frozen on load", key_data, 8'h14);
        chk(key_req === 1'b0, "R7 no req when frozen", key_req, 0);
        wait_pos(0);
        wait_pos(8 * T + 3);
        chk(key_data === 8'h87, "R3 K3/S7 word", key_data, 8'h87);
        do_read();

        // disabled: keys held, no strobes, zero loaded, no request
        scan_en = 1'b0;
        keys[0*8 + 0] = 1'b1;
        wait_pos(0);
        wait_pos(8 * T + 3);
        chk(key_data === 8'h00, "R6 disabled zero", key_data, 0);
        chk(key_req === 1'b0, "R6 disabled no req", key_req, 0);

        // re-enable, key at strobe 0 sampled
        scan_en = 1'b1;
        wait_pos(0);
        wait_pos(8 * T + 3);
        chk(key_data === 8'h10, "R2 K0/S0 word", key_data, 8'h10);
        keys = '0;
        repeat (10) tick();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule